// File: doc/BRIEF.md
# Tracking Angle Counter with Direction, Busy and Zero-Cross Status

This block is the digital heart of a tracking angle converter. An external error-driven oscillator produces step pulses, and a direction input says which way each one goes. On every step the block moves a natural-binary angle register up or down by one LSB. The most significant active bit is worth 180 degrees, and each lower bit is worth half of the bit above it.

Around the counter the block derives three status outputs. A direction flag records which way the code last moved. A busy flag stays high while the code is still changing. A timed zero-cross pulse marks each wrap of the code, either from all ones to all zeros or from all zeros to all ones. The active resolution can be set anywhere from 12 to 16 bits.

Top module: `angle_track_counter`

## Requirements
- R1: After reset the angle output is zero, `dir_o` is high, and `busy_o` and `zcross_o` are low.
- R2: When `step_i` is high at a clock edge with `step_up_i` high, `angle_o` is one greater from the next cycle on.
- R3: When `step_i` is high at a clock edge with `step_up_i` low, `angle_o` is one less from the next cycle on.
- R4: `res_sel_i` sets the active width N. Code 0 gives 12 bits, 1 gives 13, 2 gives 14, 3 gives 15, and 4 gives 16. Codes 5 to 7 also give 16. Only the low N bits count, and the bits of `angle_o` above N read zero.
- R5: An up step from N-bit all ones gives zero. A down step from zero gives N-bit all ones. Either wrap starts a zero-cross pulse in the next cycle.
- R6: The zero-cross pulse lasts CLK_HZ/1e6*ZPULSE_US cycles. A new wrap while the pulse is high restarts its full width.
- R7: `dir_o` takes the value of `step_up_i` from the cycle after each step and holds it while no steps occur.
- R8: `busy_o` is high for BUSY_HOLD cycles starting the cycle after a step. Each further step restarts that window.
- R9: In a cycle with no step, the angle count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One step per cycle it is high |
| step_up_i | input | 1 | Step direction, 1 = count up |
| res_sel_i | input | 3 | Resolution code, see R4 |
| angle_o | output | ANGLE_W | Natural-binary angle, masked to N bits |
| dir_o | output | 1 | Last counting direction, 1 = up |
| busy_o | output | 1 | Code changing / data unsettled |
| zcross_o | output | 1 | Timed pulse on a count wrap |

## Verification
A wrong count shows on `angle_o` one cycle after the step that caused it. Because the counter never corrects itself, the error then persists in every later comparison. A wrong width mask shows up in one of two ways: bits appear above N at once, or the zero-cross pulse is missing or comes late at the wrap boundary. Faults in the busy or pulse timers show at the fall edge of those outputs. For busy that is BUSY_HOLD cycles after the last step, and for the zero-cross pulse it is the pulse width after the last wrap. The bench therefore compares every output on every cycle against a model.

// File: rtl/angle_track_counter.sv
module angle_track_counter #(
  parameter int ANGLE_W   = 16,
  parameter int MIN_RES   = 12,
  parameter int CLK_HZ    = 100_000_000,
  parameter int ZPULSE_US = 200,
  parameter int BUSY_HOLD = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic               step_up_i,
  input  logic [2:0]         res_sel_i,
  output logic [ANGLE_W-1:0] angle_o,
  output logic               dir_o,
  output logic               busy_o,
  output logic               zcross_o
);
  localparam int ZP_CYC = (CLK_HZ / 1_000_000) * ZPULSE_US;
  localparam int ZW     = $clog2(ZP_CYC + 1);
  localparam int BW     = $clog2(BUSY_HOLD + 1);

  logic [ANGLE_W-1:0] angle_q, mask, cur;
  logic [ZW-1:0]      zcnt;
  logic [BW-1:0]      bcnt;
  logic               wrap;
  int                 nbits;

  always_comb begin
    nbits = MIN_RES + int'(res_sel_i);
    if (nbits > ANGLE_W) nbits = ANGLE_W;
    for (int i = 0; i < ANGLE_W; i++) mask[i] = (i < nbits);
  end

  assign cur     = angle_q & mask;
  assign wrap    = step_i && (step_up_i ? (cur == mask) : (cur == '0));
  assign angle_o = cur;
  assign busy_o  = (bcnt != '0);
  assign zcross_o = (zcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      angle_q <= '0;
      dir_o   <= 1'b1;
    end else if (step_i) begin
      angle_q <= (step_up_i ? cur + 1'b1 : cur - 1'b1) & mask;
      dir_o   <= step_up_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            bcnt <= '0;
    else if (step_i)       bcnt <= BW'(BUSY_HOLD);
    else if (bcnt != '0)   bcnt <= bcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            zcnt <= '0;
    else if (wrap)         zcnt <= ZW'(ZP_CYC);
    else if (zcnt != '0)   zcnt <= zcnt - 1'b1;
  end

  // R9
  no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(angle_q));
  // R8
  busy_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> busy_o);
  // R7
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> dir_o == $past(step_up_i));
  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(dir_o));
  // R5
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && step_up_i && angle_o == mask) |=> (zcross_o && angle_q == '0));
  // R6
  zc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zcross_o) |-> !$past(wrap));
endmodule

// File: tb/sim_angle_track_counter.sv
module sim_angle_track_counter;
  localparam int BH = 4;
  localparam int ZP = 200;

  logic clk = 0, rst_n = 0, step = 0, up = 0;
  logic [2:0] res = 3'd4;
  logic [15:0] angle;
  logic dir, busy, zc;

  angle_track_counter #(.ANGLE_W(16), .MIN_RES(12), .CLK_HZ(1_000_000),
    .ZPULSE_US(200), .BUSY_HOLD(BH)) u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step), .step_up_i(up), .res_sel_i(res),
    .angle_o(angle), .dir_o(dir), .busy_o(busy), .zcross_o(zc));

  always #5 clk = ~clk;

  logic [18:0] exp_q[$];
  string       tag_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_ang = 0;
  logic m_dir = 1;
  int m_b = 0, m_z = 0;

  function automatic logic [15:0] mk(input logic [2:0] r);
    int n = 12 + int'(r);
    if (n > 16) n = 16;
    return 16'((17'd1 << n) - 1);
  endfunction

  task automatic cyc(input logic s, input logic u, input logic [2:0] r, input string tag);
    logic [15:0] m, c;
    bit w;
    @(negedge clk);
    step = s; up = u; res = r;
    m = mk(r); c = m_ang & m;
    w = s && (u ? (c == m) : (c == 0));
    if (s) begin
      m_ang = (u ? c + 16'd1 : c - 16'd1) & m;
      m_dir = u; m_b = BH;
    end else if (m_b > 0) m_b--;
    if (w) m_z = ZP; else if (m_z > 0) m_z--;
    exp_q.push_back({m_ang & m, m_dir, m_b != 0, m_z != 0});
    tag_q.push_back(tag);
  endtask

  always begin
    @(posedge clk); #2;
    if (exp_q.size() > 0) begin
      logic [18:0] e, a;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      a = {angle, dir, busy, zc};
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: got ang=%h dir=%b busy=%b zc=%b, want ang=%h dir=%b busy=%b zc=%b",
          t, a[18:3], a[2], a[1], a[0], e[18:3], e[2], e[1], e[0]);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang, want completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(0, 0, 4, "R1");                                  // R1 reset state
    cyc(0, 0, 4, "R9");                                  // R9 idle hold
    for (int i = 0; i < 5; i++) cyc(1, 1, 4, "R2");      // R2 up steps, R8 busy
    for (int i = 0; i < BH + 2; i++) cyc(0, 0, 4, "R8"); // R8 busy fall, R7 dir hold
    for (int i = 0; i < 3; i++) cyc(1, 0, 4, "R3");      // R3 down, R7 dir low
    for (int i = 0; i < 3; i++) cyc(1, 0, 4, "R5");      // R5 wrap down at 16 bits
    for (int i = 0; i < ZP + 3; i++) cyc(0, 1, 4, "R6"); // R6 pulse width
    cyc(0, 0, 0, "R4");                                  // R4 12-bit view masks high bits
    cyc(1, 1, 0, "R5");                                  // R5 12-bit up wrap to zero
    for (int i = 0; i < 50; i++) cyc(0, 0, 0, "R6");
    cyc(1, 0, 0, "R6");                                  // R6 retrigger by down wrap
    for (int i = 0; i < ZP + 3; i++) cyc(0, 0, 0, "R6");
    cyc(0, 0, 7, "R4");                                  // R4 code 7 acts as 16 bits
    cyc(0, 0, 2, "R4");                                  // R4 14-bit view
    for (int i = 0; i < 12; i++) cyc(i % 2 == 0, 1, 2, "R8"); // R8 busy retrigger
    for (int i = 0; i < 8; i++) cyc(0, 0, 2, "R7");      // R7 dir stays high
    for (int i = 0; i < 4; i++) cyc(1, 1, 3, "R2");      // R2 at 15 bits
    for (int i = 0; i < BH + 2; i++) cyc(0, 0, 3, "R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule